// File: doc/BRIEF.md
# Four-Lane Multi-Output FIR Engine

This engine evaluates a finite impulse response filter four outputs at a time. Four multiply-accumulate lanes work side by side. Lane j owns output y(n+j) of the current group. All four lanes share one coefficient per cycle and one sliding set of input samples. Each compute cycle fetches exactly one coefficient and one new sample. That sample is the next older one, and it enters the window at lane 0. The entries already in the window move up one lane, so lanes reuse samples instead of fetching them again. Each lane adds its products in rising coefficient order. Its result therefore matches a plain one-MAC-per-cycle evaluation bit for bit.

To start a job, pulse `start` with a base sample index n, a tap count N and a group count B. For each group, the engine first makes three priming reads that load x(n+3), x(n+2) and x(n+1) into the window. It then runs N compute cycles, presents the four results with a one-cycle `done` pulse, and moves the base up by four for the next group. Both memories answer one cycle after a read enable. Samples with a negative index are never fetched; they count as zero, as if the filter started from rest.

Top module: `mfir_engine`

## Requirements
- R1: After a group with base n and tap count N, output lane j (j = 0..3, lane j at bits 40*j+39 down to 40*j of `y`) equals the sum over k = 0..N-1 of w(k)·x(n+j−k).
- R2: Each lane forms 40-bit signed sums of sign-extended 32-bit products, added in increasing k order and wrapping modulo 2^40, so the result is bit-exact against a sequential single-MAC evaluation.
- R3: In each compute cycle exactly one coefficient read is issued. Within a group, coefficient addresses run 0, 1, ..., N−1 on consecutive cycles. A group makes N coefficient reads in total.
- R4: Each group reads samples at descending addresses: n+3, n+2, n+1 during priming, then n−k in compute cycle k. There is at most one sample read per cycle.
- R5: A sample whose index is below zero produces no read and enters the window as zero.
- R6: Any tap count from 1 to 64 gives correct results.
- R7: `done` is high for a single cycle. `y` changes only in a cycle where `done` is high, and it holds its value until the next `done`.
- R8: A `start` that arrives while `busy` is high has no effect. It causes no extra reads, no extra `done` and no change to any result.
- R9: A job of B groups (1..16) produces B `done` pulses. Group b uses base n+4b.
- R10: After reset, `busy`, `done` and `y` are zero and no memory read is issued.
- R11: `done` for the first group is high in the cycle that follows the (N+5)th rising edge after the edge that accepts `start`. Later groups follow every N+3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a job when the engine is idle |
| base_idx | input | 10 | Sample index n of the first output of the first group |
| taps | input | 7 | Tap count N, 1 to 64 |
| blocks | input | 5 | Number of four-output groups, 1 to 16 |
| busy | output | 1 | High while the engine is issuing reads |
| coef_rd_en | output | 1 | Coefficient memory read enable |
| coef_addr | output | 6 | Coefficient index k |
| coef_data | input | 16 | Signed coefficient, returned one cycle after the read |
| samp_rd_en | output | 1 | Sample memory read enable |
| samp_addr | output | 10 | Sample index |
| samp_data | input | 16 | Signed sample, returned one cycle after the read |
| done | output | 1 | One-cycle pulse marking `y` as a new group of results |
| y | output | 160 | Four 40-bit signed results, lane 0 in the low bits |

## Verification
The checker properties assume several things about the inputs. The tap count and group count stay in range. Every sample index up to n+4B+2 lies inside the memory. The memories return data exactly one cycle after a read enable. The stimulus keeps these limits: it uses bases no higher than 700, at most four groups and at most 64 taps, and its memory models register their output on the enable. To catch wrapped or out-of-range reads, the top of the sample memory holds a distinctive trap value. A `start` is also injected during priming, to show that a busy engine ignores it.

// File: rtl/mfir_pkg.sv
package mfir_pkg;

    localparam int LANES      = 4;
    localparam int SAMP_W     = 16;
    localparam int COEF_W     = 16;
    localparam int ACC_W      = 40;
    localparam int PROD_W     = SAMP_W + COEF_W;
    localparam int MAX_TAPS   = 64;
    localparam int TAP_W      = $clog2(MAX_TAPS + 1);
    localparam int CADDR_W    = $clog2(MAX_TAPS);
    localparam int SADDR_W    = 10;
    localparam int MAX_BLOCKS = 16;
    localparam int BLK_W      = $clog2(MAX_BLOCKS + 1);
    localparam int PRIME_LEN  = LANES - 1;
    localparam int PCNT_W     = (PRIME_LEN > 1) ? $clog2(PRIME_LEN) : 1;

    typedef logic signed [SAMP_W-1:0]  samp_t;
    typedef logic signed [COEF_W-1:0]  coef_t;
    typedef logic signed [ACC_W-1:0]   acc_t;
    typedef logic signed [SADDR_W:0]   sidx_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PRIME,
        SEQ_RUN
    } seq_state_e;

    // Control that travels with a fetch until its data returns.
    typedef struct packed {
        logic shift;  // a sample slot enters the window
        logic zero;   // the slot is below index zero
        logic mac;    // the lanes accumulate
        logic clr;    // first tap of a group
        logic last;   // final tap of a group
    } lane_ctl_t;

    function automatic acc_t mac_step(input acc_t acc_in, input coef_t w, input samp_t x);
        logic signed [PROD_W-1:0] prod;
        prod = w * x;
        return acc_in + {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    endfunction

endpackage

// File: rtl/mfir_seq.sv
module mfir_seq
    import mfir_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [SADDR_W-1:0] base_idx,
    input  logic [TAP_W-1:0]   taps,
    input  logic [BLK_W-1:0]   blocks,
    output logic               busy,
    output logic               coef_rd_en,
    output logic [CADDR_W-1:0] coef_addr,
    output logic               samp_rd_en,
    output logic [SADDR_W-1:0] samp_addr,
    output lane_ctl_t          ctl
);

    seq_state_e         state_q;
    sidx_t              base_q;
    logic [TAP_W-1:0]   taps_q;
    logic [BLK_W-1:0]   blk_left_q;
    logic [PCNT_W-1:0]  pcnt_q;
    logic [CADDR_W-1:0] k_q;

    sidx_t idx;
    logic  last_tap;
    logic  running;

    always_comb begin
        if (state_q == SEQ_PRIME) begin
            idx = base_q + sidx_t'(PRIME_LEN) - sidx_t'(pcnt_q);
        end else begin
            idx = base_q - sidx_t'(k_q);
        end
        running    = (state_q == SEQ_RUN);
        last_tap   = (TAP_W'(k_q) == taps_q - TAP_W'(1));
        busy       = (state_q != SEQ_IDLE);
        coef_rd_en = running;
        coef_addr  = k_q;
        samp_rd_en = busy && !idx[SADDR_W];
        samp_addr  = idx[SADDR_W-1:0];
        ctl.shift  = busy;
        ctl.zero   = idx[SADDR_W];
        ctl.mac    = running;
        ctl.clr    = running && (k_q == '0);
        ctl.last   = running && last_tap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            base_q     <= '0;
            taps_q     <= '0;
            blk_left_q <= '0;
            pcnt_q     <= '0;
            k_q        <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        base_q     <= sidx_t'({1'b0, base_idx});
                        taps_q     <= taps;
                        blk_left_q <= blocks;
                        pcnt_q     <= '0;
                        k_q        <= '0;
                        state_q    <= SEQ_PRIME;
                    end
                end
                SEQ_PRIME: begin
                    if (pcnt_q == PCNT_W'(PRIME_LEN - 1)) begin
                        pcnt_q  <= '0;
                        k_q     <= '0;
                        state_q <= SEQ_RUN;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                SEQ_RUN: begin
                    if (last_tap) begin
                        k_q <= '0;
                        if (blk_left_q == BLK_W'(1)) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            blk_left_q <= blk_left_q - 1'b1;
                            base_q     <= base_q + sidx_t'(LANES);
                            state_q    <= SEQ_PRIME;
                        end
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mfir_window.sv
module mfir_window
    import mfir_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                shift,
    input  logic                zero,
    input  samp_t               din,
    output samp_t [LANES-1:0]   lane_x
);

    // Only LANES-1 entries are kept: the oldest lane value is dropped on shift.
    samp_t hist_q [PRIME_LEN];

    assign lane_x[0] = zero ? samp_t'(0) : din;

    for (genvar j = 1; j < LANES; j++) begin : g_tap
        assign lane_x[j] = hist_q[j-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PRIME_LEN; i++) hist_q[i] <= '0;
        end else if (shift) begin
            for (int i = 0; i < PRIME_LEN; i++) hist_q[i] <= lane_x[i];
        end
    end

endmodule

// File: rtl/mfir_mac_lane.sv
module mfir_mac_lane
    import mfir_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mac,
    input  logic  clr,
    input  coef_t w,
    input  samp_t x,
    output acc_t  acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (mac) begin
            acc <= mac_step(clr ? acc_t'(0) : acc, w, x);
        end
    end

endmodule

// File: rtl/mfir_engine.sv
module mfir_engine
    import mfir_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [SADDR_W-1:0]           base_idx,
    input  logic [TAP_W-1:0]             taps,
    input  logic [BLK_W-1:0]             blocks,
    output logic                         busy,
    output logic                         coef_rd_en,
    output logic [CADDR_W-1:0]           coef_addr,
    input  logic [COEF_W-1:0]            coef_data,
    output logic                         samp_rd_en,
    output logic [SADDR_W-1:0]           samp_addr,
    input  logic [SAMP_W-1:0]            samp_data,
    output logic                         done,
    output logic [LANES-1:0][ACC_W-1:0]  y
);

    lane_ctl_t                   issue_ctl;
    lane_ctl_t                   data_ctl_q;   // aligned with returning memory data
    samp_t [LANES-1:0]           lane_x;
    acc_t                        lane_acc [LANES];
    logic                        capture_q;
    logic                        done_q;
    logic [LANES-1:0][ACC_W-1:0] y_q;

    mfir_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .base_idx   (base_idx),
        .taps       (taps),
        .blocks     (blocks),
        .busy       (busy),
        .coef_rd_en (coef_rd_en),
        .coef_addr  (coef_addr),
        .samp_rd_en (samp_rd_en),
        .samp_addr  (samp_addr),
        .ctl        (issue_ctl)
    );

    mfir_window u_win (
        .clk    (clk),
        .rst    (rst),
        .shift  (data_ctl_q.shift),
        .zero   (data_ctl_q.zero),
        .din    ($signed(samp_data)),
        .lane_x (lane_x)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        mfir_mac_lane u_lane (
            .clk (clk),
            .rst (rst),
            .mac (data_ctl_q.mac),
            .clr (data_ctl_q.clr),
            .w   ($signed(coef_data)),
            .x   (lane_x[j]),
            .acc (lane_acc[j])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_ctl_q <= '0;
            capture_q  <= 1'b0;
            done_q     <= 1'b0;
            y_q        <= '0;
        end else begin
            data_ctl_q <= issue_ctl;
            capture_q  <= data_ctl_q.last;
            done_q     <= capture_q;
            if (capture_q) begin
                for (int j = 0; j < LANES; j++) y_q[j] <= lane_acc[j];
            end
        end
    end

    assign done = done_q;
    assign y    = y_q;

endmodule

// File: rtl/mfir_engine_chk.sv
module mfir_engine_chk
    import mfir_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        busy,
    input logic                        coef_rd_en,
    input logic [CADDR_W-1:0]          coef_addr,
    input logic                        samp_rd_en,
    input logic [SADDR_W-1:0]          samp_addr,
    input logic                        done,
    input logic [LANES-1:0][ACC_W-1:0] y
);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!coef_rd_en && !samp_rd_en));

    p_coef_first_r3: assert property (@(posedge clk) disable iff (rst)
        (coef_rd_en && !$past(coef_rd_en)) |-> (coef_addr == '0));

    p_coef_step_r3: assert property (@(posedge clk) disable iff (rst)
        (coef_rd_en && coef_addr != '0) |->
            ($past(coef_rd_en) && coef_addr == $past(coef_addr) + 1'b1));

    p_samp_desc_r4: assert property (@(posedge clk) disable iff (rst)
        (coef_rd_en && coef_addr != '0 && samp_rd_en) |->
            ($past(samp_rd_en) && samp_addr == $past(samp_addr) - 1'b1));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_y_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(y));

endmodule

bind mfir_engine mfir_engine_chk u_chk (.*);

// File: tb/sim_mfir_engine.sv
module sim_mfir_engine;
    import mfir_pkg::*;

    localparam int CLK_PERIOD  = 10;
    localparam int WDOG_CYCLES = 20000;
    localparam int SMEM_DEPTH  = 1 << SADDR_W;
    localparam int TRAP_FROM   = SMEM_DEPTH - 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [SADDR_W-1:0] base_idx = '0;
    logic [TAP_W-1:0]   taps = '0;
    logic [BLK_W-1:0]   blocks = '0;
    logic busy, coef_rd_en, samp_rd_en, done;
    logic [CADDR_W-1:0] coef_addr;
    logic [SADDR_W-1:0] samp_addr;
    logic [COEF_W-1:0]  coef_data;
    logic [SAMP_W-1:0]  samp_data;
    logic [LANES-1:0][ACC_W-1:0] y;

    logic [COEF_W-1:0] cmem [MAX_TAPS];
    logic [SAMP_W-1:0] smem [SMEM_DEPTH];

    int n_checks = 0;
    int n_fail = 0;
    int coef_reads = 0;
    int samp_reads = 0;
    int done_seen = 0;
    logic [LANES-1:0][ACC_W-1:0] exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mfir_engine u0 (.*);

    always_ff @(posedge clk) begin
        if (coef_rd_en) coef_data <= cmem[coef_addr];
        if (samp_rd_en) samp_data <= smem[samp_addr];
    end

    always @(negedge clk) begin
        if (coef_rd_en) coef_reads <= coef_reads + 1;
        if (samp_rd_en) samp_reads <= samp_reads + 1;
        if (done)       done_seen  <= done_seen + 1;
    end

    task automatic check_int(input bit ok, input string req, input string what,
                             input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_acc(input bit ok, input string req, input string what,
                             input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%h expected 0x%h", req, what, act, exp);
        end
    endtask

    // Sequential reference: one product per step, increasing k, 40-bit wrap.
    function automatic logic [ACC_W-1:0] ref_out(input int n, input int ntap, input int lane);
        logic signed [ACC_W-1:0]  a;
        logic signed [PROD_W-1:0] p;
        logic signed [SAMP_W-1:0] xv;
        int idx;
        a = '0;
        for (int k = 0; k < ntap; k++) begin
            idx = n + lane - k;
            xv  = (idx < 0) ? '0 : $signed(smem[idx[SADDR_W-1:0]]);
            p   = $signed(cmem[k[CADDR_W-1:0]]) * xv;
            a   = a + ACC_W'(p);
        end
        return a;
    endfunction

    function automatic int exp_samp_reads(input int n, input int ntap);
        int cnt;
        cnt = 0;
        for (int i = n - ntap + 1; i <= n + PRIME_LEN; i++) if (i >= 0) cnt++;
        return cnt;
    endfunction

    task automatic monitor();
        logic [LANES-1:0][ACC_W-1:0] e;
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                if (exp_q.size() == 0) begin
                    check_int(1'b0, "R8", "unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    for (int j = 0; j < LANES; j++)
                        check_acc(y[j] == e[j], "R1 R2", $sformatf("lane %0d", j), y[j], e[j]);
                    @(negedge clk);
                    check_int(!done, "R7", "done width", int'(done), 0);
                    check_acc(y[0] == e[0] && y[LANES-1] == e[LANES-1], "R7", "y hold",
                              y[0], e[0]);
                end
            end
        end
    endtask

    task automatic run_job(input int n, input int ntap, input int nblk, input bit inject,
                           input string rd_req);
        int c0, s0, d0, edges, exp_s;
        logic [LANES-1:0][ACC_W-1:0] e;
        exp_s = 0;
        for (int b = 0; b < nblk; b++) begin
            for (int j = 0; j < LANES; j++) e[j] = ref_out(n + LANES * b, ntap, j);
            exp_q.push_back(e);
            exp_s += exp_samp_reads(n + LANES * b, ntap);
        end
        @(negedge clk);
        c0 = coef_reads;
        s0 = samp_reads;
        d0 = done_seen;
        start    = 1'b1;
        base_idx = SADDR_W'(n);
        taps     = TAP_W'(ntap);
        blocks   = BLK_W'(nblk);
        edges    = 0;
        while (1) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (inject && edges == 2) begin
                start    = 1'b1;
                base_idx = SADDR_W'(n + 40);
                taps     = TAP_W'(3);
                blocks   = BLK_W'(1);
            end else begin
                start = 1'b0;
            end
            if (done || edges > ntap + 60) break;
        end
        start = 1'b0;
        check_int(edges == ntap + 6, "R11", "first done latency", edges, ntap + 6);
        while (done_seen < d0 + nblk) @(posedge clk);
        repeat (ntap + 12) @(posedge clk);
        @(negedge clk);
        check_int(done_seen - d0 == nblk, "R9", "done count", done_seen - d0, nblk);
        check_int(coef_reads - c0 == ntap * nblk, "R3", "coef reads", coef_reads - c0, ntap * nblk);
        check_int(samp_reads - s0 == exp_s, rd_req, "sample reads", samp_reads - s0, exp_s);
        check_int(exp_q.size() == 0, "R9", "groups pending", exp_q.size(), 0);
    endtask

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        for (int i = 0; i < SMEM_DEPTH; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            smem[i] = seed[31:16];
        end
        for (int i = 0; i < MAX_TAPS; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            cmem[i] = seed[31:16];
        end
        for (int i = TRAP_FROM; i < SMEM_DEPTH; i++) smem[i] = 16'h7abc;
        cmem[0]   = 16'h8000;
        cmem[5]   = 16'h7fff;
        smem[100] = 16'h8000;
        smem[101] = 16'h8000;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_int(!busy && !done, "R10", "busy/done after reset", int'({busy, done}), 0);
        check_acc(y[0] == '0 && y[LANES-1] == '0, "R10", "y after reset", y[0], '0);
        check_int(coef_reads + samp_reads == 0, "R10", "reads after reset",
                  coef_reads + samp_reads, 0);

        fork
            monitor();
        join_none

        fork
            begin
                run_job(100, 16, 1, 1'b0, "R4");
                run_job(50, 1, 1, 1'b0, "R6");
                run_job(1, 8, 3, 1'b0, "R5");
                run_job(0, 64, 2, 1'b0, "R5 R6");
                run_job(300, 7, 2, 1'b1, "R8");
                run_job(700, 33, 4, 1'b0, "R4");
            end
            begin
                repeat (WDOG_CYCLES) @(posedge clk);
                check_int(1'b0, "watchdog", "run did not finish", WDOG_CYCLES, 0);
            end
        join_any

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule